// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Tri-State Bus

This block is the digital half of a 12-bit successive-approximation analog-to-digital converter. A host controls it with three inputs: a read/convert strobe, an active-low select and an upper-byte enable. A valid start puts the converter into hold, and the block then runs one bit decision per time slot, most significant bit first. For each decision it drives a trial word toward the capacitor array and reads back a single comparator bit. At the end it latches the code and releases an active-high ready flag. Ready is low for the whole conversion.

The result reaches the host over a 12-pin output bus. The bus is modelled as a data vector plus a per-pin output-enable vector, where enable low stands for high impedance. The host can read the code as one 12-bit word or as two bytes. The conversion time is a parameter counted in system clock cycles, and the decisions are spread evenly across it. The strobe, select and upper-byte inputs are asynchronous, so each passes through a two-stage synchroniser before use.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion starts only when the synchronised strobe goes from 1 to 0 while select is 0, upper-byte enable is 0 and ready is 1. Nothing else starts one: not a rising strobe, not a low strobe level, not a falling strobe with select 1, and not a falling strobe with upper-byte enable 1.
- R2: Ready is 0 for exactly NBITS*(CONV_CYCLES/NBITS)+1 clock cycles per conversion. This is 37 cycles with NBITS=12 and CONV_CYCLES=36. Ready returns to 1 one cycle after the result has been latched.
- R3: While ready is 0, changes on strobe, select and upper-byte enable have no effect. They do not shorten or restart the conversion, they do not alter its result, and they do not start a further conversion once it ends.
- R4: Every bit of the output-enable vector is 1 when strobe is 1, select is 0 and ready is 1, all at once. Otherwise every bit is 0. The enable settles within 3 clock cycles of an input change.
- R5: With upper-byte enable 0, the data pins carry the latched 12-bit code with bit 11 as the MSB.
- R6: With upper-byte enable 1, data pins 3..0 carry code bits 11..8, pins 7..4 are driven 0, and pins 11..8 keep code bits 11..8.
- R7: Decisions run MSB first. The first trial word after a start is 0x800. Each slot sets its trial bit, and the bit is kept when the comparator input is 1 at the end of the slot. The code is offset binary: with a comparator that reports input ≥ trial word, the result equals the input code, where 0x000 is negative full scale, 0x7FF is just below zero, 0x800 is just above zero and 0xFFF is positive full scale.
- R8: During and after reset, ready is 1, output enables are 0 and data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Read/convert strobe, asynchronous; a falling edge requests a conversion |
| sel_n | input | 1 | Active-low select, asynchronous |
| upper_en | input | 1 | Upper-byte enable, asynchronous |
| cmp_in | input | 1 | Comparator result for the current trial word (1 = input at or above trial) |
| rdy | output | 1 | High when idle; low for the whole conversion |
| trial_word | output | 12 | Trial code driven to the capacitor array |
| bus_data | output | 12 | Output bus data values |
| bus_oe | output | 12 | Per-pin output enable; 0 means high impedance |

## Verification
The hardest case to reach is a storm of strobe, select and upper-byte edges that lands inside a running conversion. To check it, the bench must show that none of these edges shortens the conversion, corrupts the code, enables the bus or starts a new conversion after the current one ends. The bench toggles all three inputs on every cycle of one conversion and stops a few cycles before the expected end, so that no edge is still in the synchroniser when ready returns. It then measures the ready-low length, watches the enables throughout, and checks that ready stays high for twenty further cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_t;
endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_a,
  input  logic sel_n_a,
  input  logic upper_a,
  input  logic busy_i,
  output logic start_o,
  output logic strobe_s,
  output logic sel_n_s,
  output logic upper_s
);
  logic [SYNC-1:0] strobe_sh, sel_sh, upper_sh;
  logic            strobe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_sh   <= '1;
      sel_sh      <= '1;
      upper_sh    <= '0;
      strobe_prev <= 1'b1;
    end else begin
      strobe_sh   <= {strobe_sh[SYNC-2:0], strobe_a};
      sel_sh      <= {sel_sh[SYNC-2:0], sel_n_a};
      upper_sh    <= {upper_sh[SYNC-2:0], upper_a};
      strobe_prev <= strobe_sh[SYNC-1];
    end
  end

  assign strobe_s = strobe_sh[SYNC-1];
  assign sel_n_s  = sel_sh[SYNC-1];
  assign upper_s  = upper_sh[SYNC-1];

  // R1: falling strobe, qualified by select, upper-byte and idle
  assign start_o = strobe_prev & ~strobe_s & ~sel_n_s & ~upper_s & ~busy_i;
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int NBITS       = 12,
  parameter int CONV_CYCLES = 270
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] result_o
);
  localparam int STEP = CONV_CYCLES / NBITS;
  localparam int CW   = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int IW   = $clog2(NBITS);
  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  eng_state_t       state_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    idx_q;
  logic [NBITS-1:0] trial_q, result_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ENG_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start_i) begin
            state_q <= ENG_RUN;
            cnt_q   <= '0;
            idx_q   <= IW'(NBITS-1);
            trial_q <= MSB_ONLY;
          end
        end
        ENG_RUN: begin
          if (cnt_q == CW'(STEP-1)) begin
            cnt_q          <= '0;
            trial_q[idx_q] <= cmp_i;
            if (idx_q == '0) begin
              result_q <= {trial_q[NBITS-1:1], cmp_i};
              state_q  <= ENG_DONE;
            end else begin
              idx_q                <= idx_q - 1'b1;
              trial_q[idx_q - 1'b1] <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_DONE: state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ENG_IDLE);
  assign trial_o  = trial_q;
  assign result_o = result_q;

  // R3: bit index moves only at slot ends, whatever the inputs do
  a_r3_idx_steady: assert property (@(posedge clk) disable iff (rst)
    (state_q == ENG_RUN && cnt_q != CW'(STEP-1)) |=> $stable(idx_q));

  // R2: busy released only right after the result latch cycle
  a_r2_release_after_latch: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(state_q) == ENG_DONE);

  // R7: first trial word is the MSB alone
  a_r7_first_trial: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> trial_q == MSB_ONLY);
endmodule

// File: rtl/sar_bus_out.sv
module sar_bus_out #(
  parameter int NBITS = 12,
  parameter int NIB   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_s,
  input  logic             sel_n_s,
  input  logic             upper_s,
  input  logic             busy_i,
  input  logic [NBITS-1:0] result_i,
  output logic [NBITS-1:0] data_o,
  output logic [NBITS-1:0] oe_o
);
  localparam int MID = NBITS - 2*NIB;

  logic [NBITS-1:0] split_w, data_q, oe_q;
  logic             upper_q;

  assign split_w = {result_i[NBITS-1 -: NIB], {MID{1'b0}}, result_i[NBITS-1 -: NIB]};

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      oe_q    <= '0;
      upper_q <= 1'b0;
    end else begin
      data_q  <= upper_s ? split_w : result_i;
      upper_q <= upper_s;
      oe_q    <= {NBITS{strobe_s & ~sel_n_s & ~busy_i}};
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;

  // R4: an enabled bus never coincides with a running conversion
  a_r4_oe_idle: assert property (@(posedge clk) disable iff (rst)
    (|oe_q) |-> !busy_i);

  // R6: middle pins forced low in split format
  a_r6_mid_low: assert property (@(posedge clk) disable iff (rst)
    upper_q |-> data_q[2*NIB-1:NIB] == '0);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NBITS       = 12,
  parameter int CONV_CYCLES = 270
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             sel_n,
  input  logic             upper_en,
  input  logic             cmp_in,
  output logic             rdy,
  output logic [NBITS-1:0] trial_word,
  output logic [NBITS-1:0] bus_data,
  output logic [NBITS-1:0] bus_oe
);
  logic             start_w, busy_w, strobe_s, sel_n_s, upper_s;
  logic [NBITS-1:0] result_w;

  sar_start_gate #(.SYNC(2)) u_gate (
    .clk(clk), .rst(rst),
    .strobe_a(strobe), .sel_n_a(sel_n), .upper_a(upper_en),
    .busy_i(busy_w), .start_o(start_w),
    .strobe_s(strobe_s), .sel_n_s(sel_n_s), .upper_s(upper_s)
  );

  sar_engine #(.NBITS(NBITS), .CONV_CYCLES(CONV_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start_i(start_w), .cmp_i(cmp_in),
    .busy_o(busy_w), .trial_o(trial_word), .result_o(result_w)
  );

  sar_bus_out #(.NBITS(NBITS), .NIB(NBITS/3)) u_bus (
    .clk(clk), .rst(rst),
    .strobe_s(strobe_s), .sel_n_s(sel_n_s), .upper_s(upper_s),
    .busy_i(busy_w), .result_i(result_w),
    .data_o(bus_data), .oe_o(bus_oe)
  );

  assign rdy = ~busy_w;

  // R1: conversion begins only from idle
  a_r1_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> $past(rdy) && !$past(sel_n_s) && !$past(upper_s));
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  localparam int CLK_NS = 10;
  localparam int NB     = 12;
  localparam int CONV   = 36;
  localparam int BUSY_LEN = NB * (CONV / NB) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic strobe = 1'b1, sel_n = 1'b1, upper_en = 1'b0;
  logic [NB-1:0] vin = '0;
  logic cmp_in, rdy;
  logic [NB-1:0] trial_word, bus_data, bus_oe;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;
  assign cmp_in = (trial_word <= vin);

  sar_conv_ctrl #(.NBITS(NB), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .sel_n(sel_n), .upper_en(upper_en),
    .cmp_in(cmp_in), .rdy(rdy), .trial_word(trial_word),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // count ready-low samples over n cycles
  task automatic watch_rdy(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!rdy) lows++;
    end
  endtask

  task automatic run_conv(input logic [NB-1:0] code, input bit mess,
                          output int len, output int oe_seen, output int first_trial);
    int t;
    vin = code;
    strobe = 1'b1; sel_n = 1'b0; upper_en = 1'b0;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    repeat (2) @(negedge clk);
    strobe = 1'b1;
    t = 0;
    while (rdy && t < 20) begin @(negedge clk); t++; end
    len = 0; oe_seen = 0; first_trial = trial_word;
    while (!rdy && len < 1000) begin
      len++;
      if (bus_oe != '0) oe_seen++;
      if (mess && len < BUSY_LEN - 9) begin
        strobe = len[0]; sel_n = len[1]; upper_en = len[2];
      end else begin
        strobe = 1'b1; sel_n = 1'b0; upper_en = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int len, oe_seen, ft, lows;
    logic [NB-1:0] exp_split;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b1, "R8 ready in reset", rdy, 1);
    chk(bus_oe == '0, "R8 oe in reset", bus_oe, 0);
    chk(bus_data == '0, "R8 data in reset", bus_data, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R7/R5/R2 sweep including the offset-binary corners
    for (int k = 0; k < 320; k++) begin
      logic [NB-1:0] code;
      case (k)
        0: code = 12'h000;
        1: code = 12'h7FF;
        2: code = 12'h800;
        3: code = 12'hFFF;
        default: code = NB'((k - 4) * 13);
      endcase
      run_conv(code, 1'b0, len, oe_seen, ft);
      chk(len == BUSY_LEN, "R2 busy length", len, BUSY_LEN);
      if (k == 0) chk(ft == 12'h800, "R7 first trial word", ft, 12'h800);
      repeat (5) @(negedge clk);
      chk(bus_oe == '1, "R4 oe after conversion", bus_oe, 12'hFFF);
      chk(bus_data == code, "R5 R7 result code", bus_data, code);
    end

    // R6 split format
    run_conv(12'hA5C, 1'b0, len, oe_seen, ft);
    upper_en = 1'b1;
    repeat (5) @(negedge clk);
    exp_split = {4'hA, 4'h0, 4'hA};
    chk(bus_data == exp_split, "R6 upper byte layout", bus_data, exp_split);
    chk(bus_oe == '1, "R4 oe in split format", bus_oe, 12'hFFF);
    chk(rdy == 1'b1, "R1 upper level alone no start", rdy, 1);
    upper_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(bus_data == 12'hA5C, "R5 back to word format", bus_data, 12'hA5C);

    // R1 falling strobe with select high
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    watch_rdy(12, lows);
    chk(lows == 0, "R1 no start with select high", lows, 0);
    chk(bus_oe == '0, "R4 oe off with strobe low", bus_oe, 0);
    // strobe low level with select low: no edge, no start
    sel_n = 1'b0;
    watch_rdy(12, lows);
    chk(lows == 0, "R1 low level no start", lows, 0);
    chk(bus_oe == '0, "R4 oe off strobe low select low", bus_oe, 0);
    // rising strobe does not start
    strobe = 1'b1;
    watch_rdy(12, lows);
    chk(lows == 0, "R1 rising edge no start", lows, 0);
    chk(bus_oe == '1, "R4 oe on in read window", bus_oe, 12'hFFF);
    chk(bus_data == 12'hA5C, "R5 data held", bus_data, 12'hA5C);
    // falling strobe with upper-byte enable high
    upper_en = 1'b1;
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    watch_rdy(12, lows);
    chk(lows == 0, "R1 no start with upper high", lows, 0);
    sel_n = 1'b1; upper_en = 1'b0;
    repeat (3) @(negedge clk);
    strobe = 1'b1;
    repeat (5) @(negedge clk);
    chk(bus_oe == '0, "R4 oe off with select high", bus_oe, 0);
    sel_n = 1'b0;
    repeat (5) @(negedge clk);

    // R3 input storm during a conversion
    run_conv(12'h3C1, 1'b1, len, oe_seen, ft);
    chk(len == BUSY_LEN, "R3 length under input storm", len, BUSY_LEN);
    chk(oe_seen == 0, "R4 oe stays off while busy", oe_seen, 0);
    watch_rdy(20, lows);
    chk(lows == 0, "R3 no restart after storm", lows, 0);
    chk(bus_data == 12'h3C1, "R3 result unharmed", bus_data, 12'h3C1);

    finish_run();
  end
endmodule